// File: doc/BRIEF.md
# CPU Status Register and Flag Generator

This block keeps the 16-bit status word of a small RISC processor core. From each ALU result it forms the four arithmetic flags: negative, zero, carry and signed overflow. It works on 8-bit or 16-bit results. The signed-overflow rule depends on the class of operation: addition, subtraction or compare, or a logical operation. The same word also holds the processor's control bits: the maskable-interrupt enable, the CPU halt, and three clock-source shutdown bits. The block turns these bits into control outputs for the interrupt controller and the clock generators.

The core updates the flags by pulsing `upd_i` alongside the ALU operands, result and carry-out. When the status word is the destination of a register-mode word instruction, the core loads it whole through `wr_i`. A clock-source shutdown request is passed on only while that source does not drive the main or sub-main clock. The ALU, the clock generators and the interrupt controller live outside this block.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset, `status_o` reads 0x0000 and every control output is low.
- R2: A direct write stores `wr_data_i[8:0]`; bits 15..9 of `status_o` always read zero. The field positions are: C bit 0, Z bit 1, N bit 2, interrupt enable bit 3, CPU halt bit 4, crystal-off bit 5, loop-off bit 6, oscillator-off bit 7, V bit 8.
- R3: When `wr_i` and `upd_i` are both high in one cycle, the written value is stored and the flag update is discarded.
- R4: On an update, N takes result bit 15 in word mode (`byte_i`=0) and result bit 7 in byte mode (`byte_i`=1).
- R5: On an update, Z is set exactly when the result is zero: bits 15..0 in word mode, bits 7..0 in byte mode.
- R6: On an update, C takes the value of `carry_i`.
- R7: For the add class (`op_i`=2'b01), V is set when two operands of equal sign give a result of the other sign, and is cleared otherwise. The result is `dst_i + src_i`.
- R8: For the subtract/compare class (`op_i`=2'b10), the result is `dst_i - src_i`. V is set for a non-negative minuend minus a negative subtrahend giving a negative result, and for a negative minus a non-negative giving a non-negative result. Otherwise V is cleared.
- R9: For the logical class (`op_i`=2'b00, and the unused code 2'b11), V is cleared on an update.
- R10: With `upd_i` and `wr_i` both low, the status word holds its value. A flag update never changes bits 7..3.
- R11: `irq_en_o` equals bit 3 and `cpu_halt_o` equals bit 4 of the stored word.
- R12: `dco_off_o` is bit 7 AND NOT `dco_in_use_i`. `lfxt_off_o` is bit 5 AND NOT `lfxt_in_use_i`. `fll_off_o` equals bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dst_i | input | 16 | ALU first operand (minuend for subtract) |
| src_i | input | 16 | ALU second operand |
| res_i | input | 16 | ALU result |
| carry_i | input | 1 | ALU carry-out at the selected width |
| op_i | input | 2 | Operation class: 00 logical, 01 add, 10 subtract/compare |
| byte_i | input | 1 | 1 selects 8-bit flag generation |
| upd_i | input | 1 | Load new arithmetic flags |
| wr_i | input | 1 | Direct write of the status word |
| wr_data_i | input | 16 | Direct write data |
| dco_in_use_i | input | 1 | Oscillator drives main or sub-main clock |
| lfxt_in_use_i | input | 1 | Crystal oscillator drives main or sub-main clock |
| status_o | output | 16 | Stored status word |
| irq_en_o | output | 1 | Maskable-interrupt enable |
| cpu_halt_o | output | 1 | CPU halt request |
| dco_off_o | output | 1 | Oscillator shutdown request |
| lfxt_off_o | output | 1 | Crystal oscillator shutdown request |
| fll_off_o | output | 1 | Frequency-lock loop disable |

## Verification
All state sits in one register that is driven straight onto `status_o`. A wrong flag or control bit therefore shows at the ports in the first cycle after the edge that stored it, and the gated clock outputs show it combinationally. A wrong byte/word selection or a wrong overflow polarity shows only for operand patterns whose 8-bit and 16-bit views disagree. The same holds for operands whose signs separate the add rule from the subtract rule. The stimulus therefore uses operands with different upper and lower bytes, and uses sign combinations that set V under one class but not under the other.

// File: rtl/csr_pkg.sv
package csr_pkg;

  typedef enum logic [1:0] {
    OP_LOGIC = 2'b00,
    OP_ADD   = 2'b01,
    OP_SUB   = 2'b10,
    OP_RSVD  = 2'b11
  } op_class_t;

  // Bit positions are decoded by the core and the clock generators
  localparam int unsigned SR_W     = 16;
  localparam int unsigned BIT_C    = 0;
  localparam int unsigned BIT_Z    = 1;
  localparam int unsigned BIT_N    = 2;
  localparam int unsigned BIT_IE   = 3;
  localparam int unsigned BIT_HALT = 4;
  localparam int unsigned BIT_XOFF = 5;
  localparam int unsigned BIT_LOFF = 6;
  localparam int unsigned BIT_DOFF = 7;
  localparam int unsigned BIT_V    = 8;
  localparam int unsigned USED_BITS = BIT_V + 1;
  localparam logic [SR_W-1:0] SR_MASK = SR_W'((1 << USED_BITS) - 1);

  // Signed overflow of sa + sb giving sr (sign bits only)
  function automatic logic ovf_add(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // Signed overflow of sa - sb giving sr (sign bits only)
  function automatic logic ovf_sub(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr == sb);
  endfunction

endpackage

// File: rtl/csr_flag_gen.sv
module csr_flag_gen
  import csr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] r,
  input  logic         carry,
  input  logic         byte_mode,
  input  op_class_t    op,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  localparam int unsigned HW = W / 2;

  logic sign_a, sign_b, sign_r;
  logic zero_lo, zero_full;

  always_comb begin
    sign_a    = byte_mode ? a[HW-1] : a[W-1];
    sign_b    = byte_mode ? b[HW-1] : b[W-1];
    sign_r    = byte_mode ? r[HW-1] : r[W-1];
    zero_lo   = (r[HW-1:0] == '0);
    zero_full = (r == '0);
  end

  always_comb begin
    flag_n = sign_r;
    flag_z = byte_mode ? zero_lo : zero_full;
    flag_c = carry;
    unique case (op)
      OP_ADD:  flag_v = ovf_add(sign_a, sign_b, sign_r);
      OP_SUB:  flag_v = ovf_sub(sign_a, sign_b, sign_r);
      default: flag_v = 1'b0;
    endcase
  end
endmodule

// File: rtl/csr_power_ctl.sv
module csr_power_ctl
  import csr_pkg::*;
(
  input  logic [SR_W-1:0] sr,
  input  logic            dco_in_use,
  input  logic            lfxt_in_use,
  output logic            irq_en,
  output logic            cpu_halt,
  output logic            dco_off,
  output logic            lfxt_off,
  output logic            fll_off
);
  always_comb begin
    irq_en   = sr[BIT_IE];
    cpu_halt = sr[BIT_HALT];
    dco_off  = sr[BIT_DOFF] & ~dco_in_use;
    lfxt_off = sr[BIT_XOFF] & ~lfxt_in_use;
    fll_off  = sr[BIT_LOFF];
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] dst_i,
  input  logic [15:0] src_i,
  input  logic [15:0] res_i,
  input  logic        carry_i,
  input  logic [1:0]  op_i,
  input  logic        byte_i,
  input  logic        upd_i,
  input  logic        wr_i,
  input  logic [15:0] wr_data_i,
  input  logic        dco_in_use_i,
  input  logic        lfxt_in_use_i,
  output logic [15:0] status_o,
  output logic        irq_en_o,
  output logic        cpu_halt_o,
  output logic        dco_off_o,
  output logic        lfxt_off_o,
  output logic        fll_off_o
);
  logic [SR_W-1:0] sr_q;
  logic flg_n, flg_z, flg_c, flg_v;
  logic take_write, take_flags;

  assign take_write = wr_i;
  assign take_flags = upd_i & ~wr_i;

  csr_flag_gen #(.W(SR_W)) u_flags (
    .a         (dst_i),
    .b         (src_i),
    .r         (res_i),
    .carry     (carry_i),
    .byte_mode (byte_i),
    .op        (op_class_t'(op_i)),
    .flag_n    (flg_n),
    .flag_z    (flg_z),
    .flag_c    (flg_c),
    .flag_v    (flg_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (take_write) begin
      sr_q <= wr_data_i & SR_MASK;
    end else if (take_flags) begin
      sr_q[BIT_V] <= flg_v;
      sr_q[BIT_N] <= flg_n;
      sr_q[BIT_Z] <= flg_z;
      sr_q[BIT_C] <= flg_c;
    end
  end

  assign status_o = sr_q;

  csr_power_ctl u_pwr (
    .sr          (sr_q),
    .dco_in_use  (dco_in_use_i),
    .lfxt_in_use (lfxt_in_use_i),
    .irq_en      (irq_en_o),
    .cpu_halt    (cpu_halt_o),
    .dco_off     (dco_off_o),
    .lfxt_off    (lfxt_off_o),
    .fll_off     (fll_off_o)
  );
endmodule

// File: rtl/cpu_status_reg_chk.sv
module cpu_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        carry_i,
  input logic [1:0]  op_i,
  input logic        upd_i,
  input logic        wr_i,
  input logic [15:0] wr_data_i,
  input logic        dco_in_use_i,
  input logic        lfxt_in_use_i,
  input logic [15:0] status_o,
  input logic        dco_off_o,
  input logic        lfxt_off_o
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[15:9] == 7'd0);

  p_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> status_o == ($past(wr_data_i) & 16'h01FF));

  p_carry_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !wr_i) |=> status_o[0] == $past(carry_i));

  p_logic_no_v_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !wr_i && (op_i == 2'b00 || op_i == 2'b11)) |=> !status_o[8]);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i && !wr_i) |=> $stable(status_o));

  p_ctrl_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !wr_i) |=> status_o[7:3] == $past(status_o[7:3]));

  p_dco_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dco_in_use_i |-> !dco_off_o);

  p_lfxt_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lfxt_in_use_i |-> !lfxt_off_o);
endmodule

bind cpu_status_reg cpu_status_reg_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .carry_i       (carry_i),
  .op_i          (op_i),
  .upd_i         (upd_i),
  .wr_i          (wr_i),
  .wr_data_i     (wr_data_i),
  .dco_in_use_i  (dco_in_use_i),
  .lfxt_in_use_i (lfxt_in_use_i),
  .status_o      (status_o),
  .dco_off_o     (dco_off_o),
  .lfxt_off_o    (lfxt_off_o)
);

// File: tb/cpu_status_reg_bench.sv
module cpu_status_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] dst_i, src_i, res_i, wr_data_i;
  logic        carry_i, byte_i, upd_i, wr_i, dco_in_use_i, lfxt_in_use_i;
  logic [1:0]  op_i;
  logic [15:0] status_o;
  logic        irq_en_o, cpu_halt_o, dco_off_o, lfxt_off_o, fll_off_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  cpu_status_reg u_cpu_status_reg (.*);

  // Vector fields: op[55:54] byte[53] dst[52:37] src[36:21] res[20:5] carry[4] exp VNZC[3:0]
  localparam int NV = 12;
  localparam logic [55:0] VEC [0:NV-1] = '{
    {2'b01, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 4'b1100},
    {2'b01, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'b0011},
    {2'b01, 1'b0, 16'h8000, 16'h8000, 16'h0000, 1'b1, 4'b1011},
    {2'b10, 1'b0, 16'h7FFF, 16'hFFFF, 16'h8000, 1'b0, 4'b1100},
    {2'b10, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 4'b1001},
    {2'b10, 1'b0, 16'h0005, 16'h0005, 16'h0000, 1'b1, 4'b0011},
    {2'b01, 1'b1, 16'h007F, 16'h0001, 16'h0080, 1'b0, 4'b1100},
    {2'b01, 1'b1, 16'h1280, 16'h3480, 16'h4700, 1'b1, 4'b1011},
    {2'b10, 1'b1, 16'h0080, 16'h0001, 16'h007F, 1'b1, 4'b1001},
    {2'b00, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 4'b0100},
    {2'b01, 1'b0, 16'h0040, 16'h0040, 16'h0080, 1'b0, 4'b0000},
    {2'b10, 1'b1, 16'hFF05, 16'h0105, 16'hFE00, 1'b1, 4'b0011}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dst_i = '0; src_i = '0; res_i = '0; carry_i = 1'b0; op_i = 2'b00;
    byte_i = 1'b0; upd_i = 1'b0; wr_i = 1'b0; wr_data_i = '0;
  endtask

  // Drive at negedge, let one posedge store, sample at the following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic write_sr(input logic [15:0] d);
    wr_i = 1'b1; wr_data_i = d;
    step();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    dco_in_use_i = 1'b0; lfxt_in_use_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 status", status_o, 16'h0000);
    check("R1 ctrl", {irq_en_o, cpu_halt_o, dco_off_o, lfxt_off_o, fll_off_o}, 5'b0);

    // R2 write masks reserved bits
    write_sr(16'hFFFF);
    check("R2 write", status_o, 16'h01FF);

    // Put all control bits 7..3 high; R10 says updates leave them alone
    write_sr(16'h00F8);

    for (int i = 0; i < NV; i++) begin
      op_i    = VEC[i][55:54];
      byte_i  = VEC[i][53];
      dst_i   = VEC[i][52:37];
      src_i   = VEC[i][36:21];
      res_i   = VEC[i][20:5];
      carry_i = VEC[i][4];
      upd_i   = 1'b1;
      step();
      // R4 R5 R6 R7 R8 R9 flags, R10 control bits untouched
      check($sformatf("R4-flags vec%0d", i),
            {status_o[8], status_o[2:0]}, VEC[i][3:0]);
      check($sformatf("R10 ctrl vec%0d", i), status_o[7:3], 5'b11111);
    end

    // R9 unused op code behaves as logical
    op_i = 2'b11; dst_i = 16'h7FFF; src_i = 16'h0001; res_i = 16'h8000; upd_i = 1'b1;
    step();
    check("R9 op11 V", status_o[8], 1'b0);

    // R10 hold with no update: inputs that would change flags
    op_i = 2'b01; dst_i = 16'h8000; src_i = 16'h8000; res_i = 16'h0000; carry_i = 1'b1;
    upd_i = 1'b0;
    step();
    check("R10 hold", status_o, 16'h00FC);

    // R3 write beats update
    op_i = 2'b01; dst_i = 16'h7FFF; src_i = 16'h0001; res_i = 16'h8000; carry_i = 1'b1;
    upd_i = 1'b1; wr_i = 1'b1; wr_data_i = 16'h0008;
    step();
    check("R3 priority", status_o, 16'h0008);

    // R11 interrupt enable and halt
    check("R11 ie", {irq_en_o, cpu_halt_o}, 2'b10);
    write_sr(16'h0010);
    check("R11 halt", {irq_en_o, cpu_halt_o}, 2'b01);

    // R12 gated clock shutdowns
    write_sr(16'h00E0);
    check("R12 free", {dco_off_o, lfxt_off_o, fll_off_o}, 3'b111);
    dco_in_use_i = 1'b1; #1;
    check("R12 dco busy", {dco_off_o, lfxt_off_o, fll_off_o}, 3'b011);
    lfxt_in_use_i = 1'b1; dco_in_use_i = 1'b0; #1;
    check("R12 lfxt busy", {dco_off_o, lfxt_off_o, fll_off_o}, 3'b101);
    lfxt_in_use_i = 1'b0;
    write_sr(16'h0040);
    check("R12 loop only", {dco_off_o, lfxt_off_o, fll_off_o}, 3'b001);

    // R1 reset clears a loaded word
    write_sr(16'h01FF);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    check("R1 re-reset", status_o, 16'h0000);

    finish_run();
  end
endmodule